// File: doc/BRIEF.md
# Video Line Checksum Unit

This block protects a parallel RGB pixel stream with a checksum for each video line. The transmit path adds up the red, green and blue bytes of every valid pixel in a line. Each colour has its own 8-bit sum, and the sums use ones-complement arithmetic. After the line ends, the transmit path adds one extra stream cycle that carries the inverted sums in place of a pixel. A separate checksum-valid output marks that cycle. Apart from this cycle, the stream passes through with one cycle of latency.

The receive path runs the same accumulation over the incoming line. It then checks the three checksum bytes on the marked cycle. If any channel fails, a sticky error flag is set. The flag stays high until software issues a write strobe. Both paths act only while the enable input is high. When enable is low, the stream passes unchanged and no error is raised.

Top module: `line_checksum_unit`

## Requirements
- R1: Each channel sum uses ones-complement addition. The 8-bit sum of the accumulator and the pixel byte is taken, and any carry out of bit 7 is added back into bit 0. The checksum byte sent for a channel is the bitwise inverse of its final sum.
- R2: Channels are packed in the 24-bit pixel as red in bits 23:16, green in bits 15:8 and blue in bits 7:0. The checksum cycle uses the same bit positions.
- R3: The transmit outputs (line-valid, data-valid, pixel) follow the inputs one cycle later. When line-valid was high and goes low while enabled, the next output cycle carries the checksum. In that cycle checksum-valid is 1, data-valid is 0 and line-valid is 0, and checksum-valid lasts exactly one cycle.
- R4: A rising edge of line-valid starts a fresh sum. Only cycles with both line-valid and data-valid high add a pixel. Pixels in data-valid gaps do not change the checksum.
- R5: A line that has no valid pixel produces no checksum cycle and triggers no comparison.
- R6: While enable is 0, no checksum cycle is inserted, the stream passes unchanged and the error flag is not set.
- R7: On a receive cycle with checksum-valid high, after a non-empty line, the byte pair of each channel is checked. The pair is the recomputed sum and the received byte, and their ones-complement sum must equal 0xFF. If any channel fails, the error flag is 1 from the next cycle on.
- R8: Once set, the error flag stays set across later good lines. A write strobe clears it, and the flag is 0 in the cycle after the strobe.
- R9: A failing check and a write strobe in the same cycle leave the flag set.
- R10: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Turns checksum insertion and checking on |
| tx_lv | input | 1 | Transmit line-valid |
| tx_de | input | 1 | Transmit data-valid |
| tx_pix | input | 24 | Transmit pixel {R,G,B} |
| tx_out_lv | output | 1 | Line-valid after the insertion stage |
| tx_out_de | output | 1 | Data-valid after the insertion stage |
| tx_out_pix | output | 24 | Pixel, or checksum bytes on the checksum cycle |
| tx_out_csv | output | 1 | Marks the checksum cycle |
| rx_lv | input | 1 | Receive line-valid |
| rx_de | input | 1 | Receive data-valid |
| rx_pix | input | 24 | Receive pixel or checksum bytes |
| rx_csv | input | 1 | Marks the received checksum cycle |
| status_wr | input | 1 | Write strobe that clears the error flag |
| csum_err | output | 1 | Sticky checksum error flag |

## Verification
An accumulator that is corrupted, or that misses a restart, gives a wrong checksum byte at the transmit output. That wrong byte appears one cycle after line-valid falls. In loopback, it also shows as a false error on the flag one cycle later. The bench sends the transmit output back into the receive side. It runs sweeps over line lengths, byte values and data-valid gaps, and compares each checksum cycle with sums worked out in the bench. Bit errors are injected into a chosen pixel or into the checksum byte, and the flag is checked for setting, holding, clearing and the case where an error and a clear fall in the same cycle.

// File: rtl/lcs_pkg.sv
package lcs_pkg;
    localparam int CH_W   = 8;
    localparam int NUM_CH = 3;
    localparam int PIX_W  = CH_W * NUM_CH;

    typedef logic [CH_W-1:0] chan_t;
    // index 0 = blue, 1 = green, 2 = red (red in the top byte)
    typedef logic [NUM_CH-1:0][CH_W-1:0] pix_t;

    typedef struct packed {
        logic lv;
        logic de;
        logic csv;
        pix_t pix;
    } beat_t;

    // ones-complement add: carry out of the top bit wraps into bit 0
    function automatic chan_t oc_add(chan_t a, chan_t b);
        logic [CH_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[CH_W-1:0] + chan_t'(s[CH_W]);
    endfunction
endpackage

// File: rtl/lcs_accum.sv
module lcs_accum
    import lcs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic lv,
    input  logic de,
    input  pix_t pix,
    output pix_t sum,
    output logic seen,
    output logic line_end
);
    logic lv_q;
    logic start;
    pix_t nxt;

    assign start    = lv & ~lv_q;
    assign line_end = lv_q & ~lv & seen;

    always_comb begin
        nxt = sum;
        for (int c = 0; c < NUM_CH; c++) begin
            if (start)
                nxt[c] = de ? pix[c] : '0;
            else if (lv && de)
                nxt[c] = oc_add(sum[c], pix[c]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lv_q <= 1'b0;
            seen <= 1'b0;
            sum  <= '0;
        end else begin
            lv_q <= lv;
            sum  <= nxt;
            if (start)
                seen <= de;
            else if (lv && de)
                seen <= 1'b1;
        end
    end

    // seen may only drop when a new line starts
    assert_restart_only_at_line_start_R4: assert property (
        @(posedge clk) disable iff (rst)
        $fell(seen) |-> $past(lv && !lv_q));
endmodule

// File: rtl/lcs_tx.sv
module lcs_tx
    import lcs_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  enable,
    input  beat_t in_b,
    output beat_t out_b
);
    pix_t acc_sum;
    logic acc_seen;
    logic acc_end;

    lcs_accum u_acc (
        .clk      (clk),
        .rst      (rst),
        .lv       (in_b.lv),
        .de       (in_b.de),
        .pix      (in_b.pix),
        .sum      (acc_sum),
        .seen     (acc_seen),
        .line_end (acc_end)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_b <= '0;
        end else if (enable && acc_end) begin
            out_b.lv  <= 1'b0;
            out_b.de  <= 1'b0;
            out_b.csv <= 1'b1;
            out_b.pix <= ~acc_sum;
        end else begin
            out_b.lv  <= in_b.lv;
            out_b.de  <= in_b.de;
            out_b.csv <= 1'b0;
            out_b.pix <= in_b.pix;
        end
    end

    assert_csv_single_cycle_R3: assert property (
        @(posedge clk) disable iff (rst)
        out_b.csv |=> !out_b.csv);

    assert_csv_after_line_fall_R3: assert property (
        @(posedge clk) disable iff (rst)
        out_b.csv |-> (!$past(in_b.lv) && $past(in_b.lv, 2)));

    assert_csv_needs_pixels_R5: assert property (
        @(posedge clk) disable iff (rst)
        out_b.csv |-> $past(acc_seen));

    assert_csv_needs_enable_R6: assert property (
        @(posedge clk) disable iff (rst)
        out_b.csv |-> $past(enable));
endmodule

// File: rtl/lcs_rx.sv
module lcs_rx
    import lcs_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  enable,
    input  beat_t in_b,
    input  logic  clr,
    output logic  err
);
    pix_t acc_sum;
    logic acc_seen;
    logic acc_end;
    logic pending;
    logic armed;
    logic [NUM_CH-1:0] ch_ok;
    logic bad;

    lcs_accum u_acc (
        .clk      (clk),
        .rst      (rst),
        .lv       (in_b.lv),
        .de       (in_b.de),
        .pix      (in_b.pix),
        .sum      (acc_sum),
        .seen     (acc_seen),
        .line_end (acc_end)
    );

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_cmp
            assign ch_ok[c] = (oc_add(acc_sum[c], in_b.pix[c]) == '1);
        end
    endgenerate

    assign armed = pending | acc_end;
    assign bad   = enable & in_b.csv & armed & ~(&ch_ok);

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
            err     <= 1'b0;
        end else begin
            if (in_b.csv || in_b.lv)
                pending <= 1'b0;
            else if (acc_end)
                pending <= 1'b1;
            err <= bad | (err & ~clr);
        end
    end

    assert_err_from_checksum_R7: assert property (
        @(posedge clk) disable iff (rst)
        $rose(err) |-> $past(in_b.csv && enable));

    assert_err_after_real_line_R5: assert property (
        @(posedge clk) disable iff (rst)
        $rose(err) |-> $past(acc_seen));

    assert_err_sticky_R8: assert property (
        @(posedge clk) disable iff (rst)
        $fell(err) |-> $past(clr));
endmodule

// File: rtl/line_checksum_unit.sv
module line_checksum_unit
    import lcs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             tx_lv,
    input  logic             tx_de,
    input  logic [PIX_W-1:0] tx_pix,
    output logic             tx_out_lv,
    output logic             tx_out_de,
    output logic [PIX_W-1:0] tx_out_pix,
    output logic             tx_out_csv,
    input  logic             rx_lv,
    input  logic             rx_de,
    input  logic [PIX_W-1:0] rx_pix,
    input  logic             rx_csv,
    input  logic             status_wr,
    output logic             csum_err
);
    beat_t tx_in_b;
    beat_t tx_out_b;
    beat_t rx_in_b;

    assign tx_in_b = '{lv: tx_lv, de: tx_de, csv: 1'b0, pix: tx_pix};
    assign rx_in_b = '{lv: rx_lv, de: rx_de, csv: rx_csv, pix: rx_pix};

    lcs_tx u_tx (
        .clk    (clk),
        .rst    (rst),
        .enable (enable),
        .in_b   (tx_in_b),
        .out_b  (tx_out_b)
    );

    lcs_rx u_rx (
        .clk    (clk),
        .rst    (rst),
        .enable (enable),
        .in_b   (rx_in_b),
        .clr    (status_wr),
        .err    (csum_err)
    );

    assign tx_out_lv  = tx_out_b.lv;
    assign tx_out_de  = tx_out_b.de;
    assign tx_out_pix = tx_out_b.pix;
    assign tx_out_csv = tx_out_b.csv;
endmodule

// File: tb/line_checksum_unit_test.sv
module line_checksum_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0;
    logic        tx_lv = 1'b0, tx_de = 1'b0;
    logic [23:0] tx_pix = '0;
    logic        tx_out_lv, tx_out_de, tx_out_csv;
    logic [23:0] tx_out_pix;
    logic [23:0] corrupt = '0;
    logic        status_wr = 1'b0;
    logic        csum_err;
    logic        rx_lv, rx_de, rx_csv;
    logic [23:0] rx_pix;

    int checks = 0;
    int fails  = 0;
    bit err_m  = 0;

    always #10 clk = ~clk;

    // loopback with optional bit corruption
    assign rx_lv  = tx_out_lv;
    assign rx_de  = tx_out_de;
    assign rx_csv = tx_out_csv;
    assign rx_pix = tx_out_pix ^ corrupt;

    line_checksum_unit uut (
        .clk(clk), .rst(rst), .enable(enable),
        .tx_lv(tx_lv), .tx_de(tx_de), .tx_pix(tx_pix),
        .tx_out_lv(tx_out_lv), .tx_out_de(tx_out_de),
        .tx_out_pix(tx_out_pix), .tx_out_csv(tx_out_csv),
        .rx_lv(rx_lv), .rx_de(rx_de), .rx_pix(rx_pix), .rx_csv(rx_csv),
        .status_wr(status_wr), .csum_err(csum_err)
    );

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // ones-complement byte addition done arithmetically
    function automatic logic [7:0] ocs(logic [7:0] a, logic [7:0] b);
        int s;
        s = int'(a) + int'(b);
        if (s > 255) s -= 255;
        return 8'(s);
    endfunction

    function automatic logic [23:0] gen(int seed, int i);
        logic [7:0] r, g, b;
        if (seed == -1) return 24'hFFFFFF;
        if (seed == -2) return 24'h000000;
        r = 8'((seed * 37 + i * 101) & 255);
        g = 8'(((seed * 13) ^ (i * 29)) + 7);
        b = 8'(255 - ((i * i + seed) & 255));
        return {r, g, b};
    endfunction

    // cidx: valid-pixel index to corrupt (n = checksum byte, <0 = none)
    task automatic run_line(int n, int seed, bit gaps, logic [23:0] cmask,
                            int cidx, bit clr_at_cs);
        logic [7:0] sr = 0, sg = 0, sb = 0;
        logic [23:0] prev = 0, p;
        bit prev_de = 0, prev_corr = 0, gap, mism;
        int sent = 0, cyc = 0;
        while (sent < n) begin
            @(negedge clk);
            if (cyc > 0)
                chk(tx_out_pix == prev && tx_out_de == prev_de && tx_out_lv,
                    "R3 pass-through", {4'h0, tx_out_lv, tx_out_de, 2'b0, tx_out_pix},
                    {4'h0, 1'b1, prev_de, 2'b0, prev});
            corrupt = prev_corr ? cmask : 24'h0;
            gap = gaps && (cyc % 3 == 2);
            p = gap ? (24'hA5C3E1 ^ 24'(cyc)) : gen(seed, sent);
            tx_lv = 1'b1; tx_de = !gap; tx_pix = p;
            prev_corr = !gap && (sent == cidx);
            if (!gap) begin
                sr = ocs(sr, p[23:16]); sg = ocs(sg, p[15:8]); sb = ocs(sb, p[7:0]);
                sent++;
            end
            prev = p; prev_de = !gap; cyc++;
        end
        @(negedge clk);
        chk(tx_out_pix == prev && tx_out_de == prev_de, "R3 last pixel",
            tx_out_pix, prev);
        corrupt = prev_corr ? cmask : 24'h0;
        tx_lv = 1'b0; tx_de = 1'b0; tx_pix = '0;
        @(negedge clk);
        if (enable) begin
            chk(tx_out_csv === 1'b1 && !tx_out_de && !tx_out_lv, "R3 checksum cycle",
                {tx_out_csv, tx_out_de, tx_out_lv}, 3'b100);
            chk(tx_out_pix == ~{sr, sg, sb}, "R1 R2 checksum bytes",
                tx_out_pix, ~{sr, sg, sb});
        end else begin
            chk(tx_out_csv === 1'b0, "R6 no checksum while disabled", tx_out_csv, 0);
        end
        corrupt = (cidx == n) ? cmask : 24'h0;
        status_wr = clr_at_cs;
        mism = enable && cmask != 0 && cidx >= 0 && cidx <= n;
        @(negedge clk);
        corrupt = '0; status_wr = 1'b0;
        err_m = mism || (err_m && !clr_at_cs);
        chk(csum_err == err_m, enable ? "R7 R9 error flag" : "R6 no error while disabled",
            csum_err, err_m);
    endtask

    task automatic empty_line(int len);
        repeat (len) begin
            @(negedge clk);
            tx_lv = 1'b1; tx_de = 1'b0; tx_pix = 24'h123456;
        end
        @(negedge clk);
        tx_lv = 1'b0; tx_pix = '0;
        @(negedge clk);
        chk(tx_out_csv === 1'b0, "R5 empty line has no checksum", tx_out_csv, 0);
        @(negedge clk);
        chk(csum_err == err_m, "R5 empty line no compare", csum_err, err_m);
    endtask

    task automatic clear_flag();
        @(negedge clk);
        status_wr = 1'b1;
        @(negedge clk);
        status_wr = 1'b0;
        err_m = 0;
        chk(csum_err == 1'b0, "R8 write clears flag", csum_err, 0);
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk({tx_out_lv, tx_out_de, tx_out_csv, csum_err} == 4'b0 && tx_out_pix == 0,
            "R10 reset outputs", {tx_out_lv, tx_out_de, tx_out_csv, csum_err}, 0);
        rst = 1'b0;
        enable = 1'b1;
        @(negedge clk);

        // R1 R2: every red value on single-pixel lines
        for (int v = 0; v < 256; v++) run_line(1, v, 0, 24'h0, -1, 0);
        // R1 R4: lengths 1..24 with and without data-valid gaps
        for (int n = 1; n <= 24; n++) begin
            run_line(n, n * 7, 0, 24'h0, -1, 0);
            run_line(n, n * 11 + 3, 1, 24'h0, -1, 0);
        end
        // R1 carry corners: saturated and zero lines
        run_line(9, -1, 0, 24'h0, -1, 0);
        run_line(5, -2, 1, 24'h0, -1, 0);

        // R5: empty lines
        empty_line(1);
        empty_line(4);

        // R7: corrupted pixel in green, then sticky R8 across a good line
        run_line(6, 42, 0, 24'h000100, 3, 0);
        run_line(6, 43, 0, 24'h0, -1, 0);
        chk(csum_err == 1'b1, "R8 flag holds across good line", csum_err, 1);
        clear_flag();
        // R7: corrupted checksum byte in red, pixel in blue with gaps
        run_line(4, 9, 0, 24'h010000, 4, 0);
        clear_flag();
        run_line(7, 77, 1, 24'h000080, 0, 0);
        clear_flag();
        // R9: error and clear in the same cycle
        run_line(5, 55, 0, 24'h000001, 2, 1);
        chk(csum_err == 1'b1, "R9 error beats clear", csum_err, 1);
        clear_flag();
        // clear on a good line's checksum cycle drops the flag
        run_line(3, 5, 0, 24'h200000, 1, 0);
        run_line(3, 6, 0, 24'h0, -1, 1);
        chk(csum_err == 1'b0, "R8 clear on good line", csum_err, 0);

        // R6: disabled, corrupted lines pass without error
        enable = 1'b0;
        run_line(5, 21, 0, 24'h000100, 2, 0);
        run_line(3, 22, 1, 24'h010000, 1, 0);
        chk(csum_err == 1'b0, "R6 disabled keeps flag clear", csum_err, 0);
        enable = 1'b1;
        run_line(4, 23, 0, 24'h0, -1, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule